// File: doc/BRIEF.md
# FDDI Physical Connection Controller

This block is the hardware controller for one FDDI port. It carries out the lock-step handshake with the port at the other end of the fibre. A start request puts the port into an initialization phase. The port then exchanges ten signaling bits, one at a time, using line states. A join phase follows, and after it the link is declared active. In every state the block drives a transmit line-state command to the PHY. It advances only on decoded line states received from the neighbour. Two timers govern progress: a minimum dwell, and a per-state timeout that restarts on every transition.

The port gets its ten local signaling bits as a vector. The ten bits the neighbour sends are captured into an output vector. From these the block derives three things: the link test duration it will wait for, whether the pairing forms a tree, and whether the connection must be withheld. Management can force a transmitted line state with a disable request; this maintenance mode ignores the line. Management can also send the port into trace, where it repeats the master line state. All timer limits are parameters counted in clock ticks.

Top module: `pcm_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (off), `tx_ls` is 0 (quiet), and every status output is low. The state codes are off=0, break=1, trace=2, connect=3, next=4, signal=5, join=6, verify=7, active=8, maintenance=9.
- R2: The `tx_ls` codes are quiet=0, halt=1, master=2, idle=3, pass-through=4. Off and break send quiet, connect and join send halt, next sends idle, verify and trace send master. Active sends idle until pass-through is enabled.
- R3: A start request enters break from any state except maintenance, and a stop request enters off from any state except maintenance; stop wins over start. Break moves to connect when the qualified received line state is quiet or halt. The received codes on `rx_ls` are quiet=0, halt=1, master=2, idle=3, active=4, noise=5.
- R4: In connect, received halt moves to next with the bit index cleared to 0. Received idle forces break at once. Received quiet does not cause a transition in connect.
- R5: An idle line state counts as received only after IDLE_MIN consecutive idle samples: 12 samples then a one-cycle decision. Eleven idles followed by any other code have no effect.
- R6: Next moves to signal on received idle. Signal transmits halt when local bit n is 1 and master when it is 0. Received halt or master returns signal to next, stores 1 or 0 into `rx_bits[n]`, and increments `bit_cnt`. This repeats for n = 0 to 9.
- R7: No transition triggered by a received line state fires until the state has lasted at least TL_MIN ticks; from a stable quiet, break reaches connect TL_MIN+1 cycles after entry. The dwell timer restarts on every transition.
- R8: In next, signal, join, verify and active, received quiet forces break, and this overrides every transition except management requests. In connect, next, signal, join and verify, reaching the timeout limit forces break; the default limit is T_OUT ticks.
- R9: The link test duration code is the larger of local and received {bit 5, bit 4} (00 short, 01 medium, 10 long, 11 extended). In next with n = 7, signal is entered exactly when that duration has elapsed, and the timeout becomes duration + T_OUT. In next with n = 9, the timeout is T_LAST.
- R10: After ten bits, received idle in next enters join. Halt in join enters verify, and master in verify enters active, raising `link_up`. In active, received idle switches `tx_ls` to pass-through. Halt forces break. A master arriving after entry to active raises `trace_prop`.
- R11: `brk_stuck` is high while break has lasted TB_MAX ticks or more, and low in every other state.
- R12: Port type is {bit 2, bit 1} (A=00, B=01, S=10, M=11). Once bit 2 has been captured, `tree_mode` is high if either port type is M. `withhold` is high if both are M. A withheld connection goes to break instead of join after the tenth bit, and withhold stays set until connect is re-entered.
- R13: A disable request enters maintenance from any state, and there `tx_ls` follows `maint_ls` while received line states, start and stop are ignored. Only an enable request leaves maintenance, going to off. A trace request in active enters trace, and trace is left only on start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_ls | input | 3 | Decoded received line state, one sample per clock |
| start_req | input | 1 | Start or restart the connection |
| stop_req | input | 1 | Return to off |
| trace_req | input | 1 | Enter trace from active |
| dis_req | input | 1 | Enter maintenance |
| en_req | input | 1 | Leave maintenance to off |
| maint_ls | input | 3 | Transmit code forced in maintenance |
| loc_bits | input | 10 | Local signaling bits, index = bit number |
| tx_ls | output | 3 | Transmit line-state command |
| state_o | output | 4 | Current state code |
| rx_bits | output | 10 | Captured neighbour signaling bits |
| bit_cnt | output | 4 | Number of bits exchanged so far |
| brk_stuck | output | 1 | Break has lasted too long |
| withhold | output | 1 | Connection withheld (M to M) |
| tree_mode | output | 1 | Either port is of type M |
| link_up | output | 1 | Connection is active |
| trace_prop | output | 1 | Master received while active |

## Verification
The assertions assume that management requests are one-cycle pulses from a single source. They also assume that `rx_ls` carries only the six defined codes. A start request pulse is taken as entering break on the next edge, while any stop or disable pulse pre-empts it. The stimulus respects these assumptions. It pulses each request for exactly one cycle and never drives an undefined code. It changes the received line state only at falling edges and holds it until the expected state appears. As a result, every line-state effect the assertions model comes from a defined, stable code.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_BREAK   = 4'd1,
    ST_TRACE   = 4'd2,
    ST_CONNECT = 4'd3,
    ST_NEXT    = 4'd4,
    ST_SIGNAL  = 4'd5,
    ST_JOIN    = 4'd6,
    ST_VERIFY  = 4'd7,
    ST_ACTIVE  = 4'd8,
    ST_MAINT   = 4'd9
  } pcm_st_e;

  // received line-state codes
  localparam logic [2:0] RX_QUIET  = 3'd0;
  localparam logic [2:0] RX_HALT   = 3'd1;
  localparam logic [2:0] RX_MASTER = 3'd2;
  localparam logic [2:0] RX_IDLE   = 3'd3;
  localparam logic [2:0] RX_ACT    = 3'd4;
  localparam logic [2:0] RX_NOISE  = 3'd5;

  // transmit commands
  localparam logic [2:0] TX_QUIET  = 3'd0;
  localparam logic [2:0] TX_HALT   = 3'd1;
  localparam logic [2:0] TX_MASTER = 3'd2;
  localparam logic [2:0] TX_IDLE   = 3'd3;
  localparam logic [2:0] TX_PASS   = 3'd4;

  function automatic logic [1:0] dur_max(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcm_ls_filter.sv
module pcm_ls_filter #(
  parameter int IDLE_MIN = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rx_ls,
  output logic [2:0] ls_q,
  output logic       ls_chg
);
  import pcm_pkg::*;

  localparam int RW = $clog2(IDLE_MIN + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(IDLE_MIN - 1);

  logic [RW-1:0] run;
  logic [2:0]    ls_nxt;

  always_comb begin
    ls_nxt = ls_q;
    if (rx_ls != RX_IDLE)     ls_nxt = rx_ls;
    else if (run == RUN_TOP)  ls_nxt = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      ls_q   <= RX_NOISE;
      ls_chg <= 1'b0;
    end else begin
      if (rx_ls == RX_IDLE) run <= (run == RUN_TOP) ? run : run + 1'b1;
      else                  run <= '0;
      ls_q   <= ls_nxt;
      ls_chg <= (ls_nxt != ls_q);
    end
  end
endmodule

// File: rtl/pcm_tmr.sv
module pcm_tmr #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] tmr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tmr <= '0;
    else if (clr)         tmr <= '0;
    else if (tmr != '1)   tmr <= tmr + 1'b1;
  end
endmodule

// File: rtl/pcm_sig.sv
module pcm_sig #(
  parameter int NB = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [3:0]    idx,
  input  logic          bit_val,
  input  logic [NB-1:0] loc_bits,
  output logic [NB-1:0] rx_bits,
  output logic [1:0]    dur_code,
  output logic          withhold,
  output logic          tree_mode
);
  import pcm_pkg::*;

  logic type_known;
  logic loc_m, rem_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_bits <= '0;
    else if (clr)                rx_bits <= '0;
    else if (cap && idx < 4'(NB)) rx_bits[idx] <= bit_val;
  end

  assign type_known = (idx > 4'd2);
  assign loc_m      = loc_bits[2] & loc_bits[1];
  assign rem_m      = rx_bits[2] & rx_bits[1];
  assign tree_mode  = type_known & (loc_m | rem_m);
  assign withhold   = type_known & loc_m & rem_m;
  assign dur_code   = dur_max(loc_bits[5:4], rx_bits[5:4]);
endmodule

// File: rtl/pcm_ctrl.sv
module pcm_ctrl #(
  parameter int NB       = 10,
  parameter int IDLE_MIN = 12,
  parameter int TL_MIN   = 8,
  parameter int T_OUT    = 300,
  parameter int TB_MAX   = 500,
  parameter int T_LAST   = 600,
  parameter int LC_SHORT = 30,
  parameter int LC_MED   = 60,
  parameter int LC_LONG  = 120,
  parameter int LC_EXT   = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rx_ls,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          trace_req,
  input  logic          dis_req,
  input  logic          en_req,
  input  logic [2:0]    maint_ls,
  input  logic [NB-1:0] loc_bits,
  output logic [2:0]    tx_ls,
  output logic [3:0]    state_o,
  output logic [NB-1:0] rx_bits,
  output logic [3:0]    bit_cnt,
  output logic          brk_stuck,
  output logic          withhold,
  output logic          tree_mode,
  output logic          link_up,
  output logic          trace_prop
);
  import pcm_pkg::*;

  localparam int M1   = (T_OUT + LC_EXT > T_LAST) ? T_OUT + LC_EXT : T_LAST;
  localparam int MAXV = (M1 > TB_MAX) ? M1 : TB_MAX;
  localparam int TW   = $clog2(MAXV + 2);
  localparam logic [3:0] LCT_BIT  = 4'd7;
  localparam logic [3:0] LAST_BIT = 4'(NB - 1);
  localparam logic [3:0] DONE_IDX = 4'(NB);

  pcm_st_e       st, nxt;
  logic [2:0]    ls_q;
  logic          ls_chg;
  logic [TW-1:0] tmr, lim, lct_t;
  logic [1:0]    dur_code;
  logic          xfer, cap, seen, pass_en;
  logic          dwell, tout, quiet_brk, wait_st, rx_hm;

  pcm_ls_filter #(.IDLE_MIN(IDLE_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .rx_ls(rx_ls), .ls_q(ls_q), .ls_chg(ls_chg));

  pcm_tmr #(.TW(TW)) u_tmr (.clk(clk), .rst_n(rst_n), .clr(xfer), .tmr(tmr));

  pcm_sig #(.NB(NB)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(xfer && nxt == ST_CONNECT), .cap(cap),
    .idx(bit_cnt), .bit_val(ls_q == RX_HALT), .loc_bits(loc_bits),
    .rx_bits(rx_bits), .dur_code(dur_code), .withhold(withhold),
    .tree_mode(tree_mode));

  function automatic logic [TW-1:0] dur_ticks(input logic [1:0] c);
    case (c)
      2'd0:    return TW'(LC_SHORT);
      2'd1:    return TW'(LC_MED);
      2'd2:    return TW'(LC_LONG);
      default: return TW'(LC_EXT);
    endcase
  endfunction

  assign lct_t = dur_ticks(dur_code);

  always_comb begin
    lim = TW'(T_OUT);
    if (st == ST_NEXT && bit_cnt == LCT_BIT)  lim = lct_t + TW'(T_OUT);
    if (st == ST_NEXT && bit_cnt == LAST_BIT) lim = TW'(T_LAST);
  end

  assign wait_st   = st inside {ST_CONNECT, ST_NEXT, ST_SIGNAL, ST_JOIN, ST_VERIFY};
  assign dwell     = (tmr >= TW'(TL_MIN));
  assign tout      = wait_st && (tmr >= lim);
  assign quiet_brk = (st inside {ST_NEXT, ST_SIGNAL, ST_JOIN, ST_VERIFY, ST_ACTIVE})
                     && (ls_q == RX_QUIET);
  assign rx_hm     = (ls_q == RX_HALT) || (ls_q == RX_MASTER);

  always_comb begin
    nxt  = st;
    xfer = 1'b0;
    cap  = 1'b0;
    if (dis_req) begin
      nxt = ST_MAINT; xfer = 1'b1;
    end else if (st == ST_MAINT) begin
      if (en_req) begin nxt = ST_OFF; xfer = 1'b1; end
    end else if (stop_req) begin
      nxt = ST_OFF; xfer = 1'b1;
    end else if (start_req) begin
      nxt = ST_BREAK; xfer = 1'b1;
    end else if (quiet_brk || tout) begin
      nxt = ST_BREAK; xfer = 1'b1;
    end else begin
      case (st)
        ST_BREAK:
          if (dwell && (ls_q == RX_QUIET || ls_q == RX_HALT)) begin
            nxt = ST_CONNECT; xfer = 1'b1;
          end
        ST_CONNECT:
          if (ls_q == RX_IDLE) begin
            nxt = ST_BREAK; xfer = 1'b1;
          end else if (dwell && ls_q == RX_HALT) begin
            nxt = ST_NEXT; xfer = 1'b1;
          end
        ST_NEXT:
          if (dwell && ls_q == RX_IDLE) begin
            if (bit_cnt == DONE_IDX) begin
              nxt = withhold ? ST_BREAK : ST_JOIN; xfer = 1'b1;
            end else if (bit_cnt != LCT_BIT || tmr >= lct_t) begin
              nxt = ST_SIGNAL; xfer = 1'b1;
            end
          end
        ST_SIGNAL:
          if (dwell && rx_hm) begin
            nxt = ST_NEXT; xfer = 1'b1; cap = 1'b1;
          end
        ST_JOIN:
          if (dwell && ls_q == RX_HALT) begin nxt = ST_VERIFY; xfer = 1'b1; end
        ST_VERIFY:
          if (dwell && ls_q == RX_MASTER) begin nxt = ST_ACTIVE; xfer = 1'b1; end
        ST_ACTIVE:
          if (ls_q == RX_HALT) begin
            nxt = ST_BREAK; xfer = 1'b1;
          end else if (trace_req) begin
            nxt = ST_TRACE; xfer = 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      bit_cnt <= '0;
      seen    <= 1'b0;
      pass_en <= 1'b0;
    end else begin
      st <= nxt;
      if (xfer && nxt == ST_CONNECT) bit_cnt <= '0;
      else if (cap)                  bit_cnt <= bit_cnt + 1'b1;
      if (xfer)        seen <= 1'b0;
      else if (ls_chg) seen <= 1'b1;
      if (xfer)                                     pass_en <= 1'b0;
      else if (st == ST_ACTIVE && ls_q == RX_IDLE)  pass_en <= 1'b1;
    end
  end

  always_comb begin
    case (st)
      ST_TRACE, ST_VERIFY: tx_ls = TX_MASTER;
      ST_CONNECT, ST_JOIN: tx_ls = TX_HALT;
      ST_NEXT:             tx_ls = TX_IDLE;
      ST_SIGNAL:           tx_ls = loc_bits[bit_cnt] ? TX_HALT : TX_MASTER;
      ST_ACTIVE:           tx_ls = pass_en ? TX_PASS : TX_IDLE;
      ST_MAINT:            tx_ls = maint_ls;
      default:             tx_ls = TX_QUIET;
    endcase
  end

  assign state_o    = st;
  assign link_up    = (st == ST_ACTIVE);
  assign brk_stuck  = (st == ST_BREAK) && (tmr >= TW'(TB_MAX));
  assign trace_prop = (st == ST_ACTIVE) && (ls_q == RX_MASTER) && (seen || ls_chg);
endmodule

// File: rtl/pcm_ctrl_chk.sv
module pcm_ctrl_chk #(
  parameter int TL_MIN = 8,
  parameter int TW     = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    st,
  input logic [2:0]    ls_q,
  input logic [TW-1:0] tmr,
  input logic          xfer,
  input logic          brk_stuck,
  input logic          withhold,
  input logic          tree_mode,
  input logic [3:0]    bit_cnt,
  input logic          trace_prop,
  input logic          dis_req,
  input logic          en_req,
  input logic          stop_req,
  input logic          start_req
);
  import pcm_pkg::*;

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st <= 4'd9);

  // R7
  break_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONNECT && $past(st) == ST_BREAK) |-> $past(tmr) >= TW'(TL_MIN));

  // R7
  timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> tmr == '0);

  // R8
  quiet_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {ST_NEXT, ST_SIGNAL, ST_JOIN, ST_VERIFY, ST_ACTIVE} && ls_q == RX_QUIET
     && !dis_req && !stop_req && !start_req) |=> st == ST_BREAK);

  // R11
  stuck_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_stuck |-> st == ST_BREAK);

  // R13
  maint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MAINT && !en_req) |=> st == ST_MAINT);

  // R13
  maint_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> st == ST_MAINT);

  // R12
  withhold_tree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    withhold |-> tree_mode);

  // R6
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd10);

  // R10
  trace_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_prop |-> st == ST_ACTIVE);
endmodule

bind pcm_ctrl pcm_ctrl_chk #(.TL_MIN(TL_MIN), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state_o), .ls_q(ls_q), .tmr(tmr), .xfer(xfer),
  .brk_stuck(brk_stuck), .withhold(withhold), .tree_mode(tree_mode),
  .bit_cnt(bit_cnt), .trace_prop(trace_prop), .dis_req(dis_req),
  .en_req(en_req), .stop_req(stop_req), .start_req(start_req));

// File: tb/pcm_ctrl_tb.sv
module pcm_ctrl_tb;
  localparam int IDLE_MIN = 12;
  localparam int TL_MIN   = 8;
  localparam int T_OUT    = 300;
  localparam int TB_MAX   = 500;
  localparam int LC_SHORT = 30;
  localparam int LC_LONG  = 120;

  localparam logic [3:0] S_OFF = 0, S_BRK = 1, S_TRC = 2, S_CON = 3, S_NXT = 4,
                         S_SIG = 5, S_JOIN = 6, S_VER = 7, S_ACT = 8, S_MNT = 9;
  localparam logic [2:0] L_Q = 0, L_H = 1, L_M = 2, L_I = 3, L_N = 5;
  localparam logic [2:0] T_Q = 0, T_H = 1, T_M = 2, T_I = 3, T_P = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] rx_ls = L_N, maint_ls = T_Q;
  logic start_req = 0, stop_req = 0, trace_req = 0, dis_req = 0, en_req = 0;
  logic [9:0] loc_bits = '0;
  logic [2:0] tx_ls;
  logic [3:0] state_o, bit_cnt;
  logic [9:0] rx_bits;
  logic brk_stuck, withhold, tree_mode, link_up, trace_prop;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_ls(rx_ls), .start_req(start_req),
    .stop_req(stop_req), .trace_req(trace_req), .dis_req(dis_req),
    .en_req(en_req), .maint_ls(maint_ls), .loc_bits(loc_bits), .tx_ls(tx_ls),
    .state_o(state_o), .rx_bits(rx_bits), .bit_cnt(bit_cnt),
    .brk_stuck(brk_stuck), .withhold(withhold), .tree_mode(tree_mode),
    .link_up(link_up), .trace_prop(trace_prop));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input logic [3:0] exp, input int maxc, output int cnt);
    cnt = 0;
    while (state_o !== exp && cnt < maxc) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; step(1); sig = 0;
  endtask

  // reach connect from any non-maintenance state
  task automatic to_connect();
    int c;
    rx_ls = L_Q;
    pulse(start_req);
    wait_st(S_CON, 50, c);
  endtask

  task automatic to_next();
    int c;
    to_connect();
    rx_ls = L_H;
    wait_st(S_NXT, 50, c);
  endtask

  // exchange ten bits from next; expects signaling to run through
  task automatic run_bits(input logic [9:0] loc, input logic [9:0] rem, input int lct);
    int c;
    loc_bits = loc;
    for (int i = 0; i < 10; i++) begin
      rx_ls = L_I;
      wait_st(S_SIG, 1000, c);
      if (i == 7) check("R9 bit7 test wait", c, lct + 1);
      check("R6 signal state", state_o, S_SIG);
      check("R6 sent bit", tx_ls, loc[i] ? T_H : T_M);
      rx_ls = rem[i] ? L_H : L_M;
      wait_st(S_NXT, 100, c);
      check("R6 captured bit", rx_bits[i], rem[i]);
      check("R6 bit count", bit_cnt, i + 1);
    end
  endtask

  task automatic t_reset();
    check("R1 state", state_o, S_OFF);
    check("R1 tx quiet", tx_ls, T_Q);
    check("R1 flags", {brk_stuck, withhold, tree_mode, link_up, trace_prop}, 0);
  endtask

  task automatic t_break();
    int c;
    rx_ls = L_N;
    pulse(start_req);
    check("R3 break entered", state_o, S_BRK);
    check("R2 break quiet", tx_ls, T_Q);
    step(TB_MAX - 10);
    check("R11 not yet stuck", brk_stuck, 0);
    step(20);
    check("R11 stuck", brk_stuck, 1);
    rx_ls = L_Q;
    wait_st(S_CON, 10, c);
    check("R3 break to connect", state_o, S_CON);
    check("R11 stuck cleared", brk_stuck, 0);
    check("R2 connect halt", tx_ls, T_H);
    pulse(start_req);
    wait_st(S_CON, 50, c);
    check("R7 dwell before connect", c, TL_MIN + 1);
  endtask

  task automatic t_connect();
    int c;
    rx_ls = L_I; step(IDLE_MIN - 1);
    rx_ls = L_N; step(5);
    check("R5 short idle ignored", state_o, S_CON);
    rx_ls = L_I;
    wait_st(S_BRK, 40, c);
    check("R4 idle breaks connect", state_o, S_BRK);
    check("R5 idle qualification delay", c, IDLE_MIN + 1);
    rx_ls = L_Q;
    wait_st(S_CON, 40, c);
    step(20);
    check("R4 quiet ignored in connect", state_o, S_CON);
    pulse(start_req);
    wait_st(S_CON, 40, c);
    rx_ls = L_N;
    wait_st(S_BRK, T_OUT + 10, c);
    check("R8 connect timeout", c, T_OUT + 1);
    rx_ls = L_Q;
    wait_st(S_CON, 40, c);
    rx_ls = L_H;
    wait_st(S_NXT, 40, c);
    check("R4 halt to next", state_o, S_NXT);
    check("R4 index cleared", bit_cnt, 0);
    check("R2 next idle", tx_ls, T_I);
  endtask

  task automatic t_full(input logic to_halt);
    int c;
    // local: type S, compat, duration 01, mac-on-output; remote: type M, duration 10
    run_bits(10'b1000011100, 10'b0101101110, LC_LONG);
    check("R12 tree mode", tree_mode, 1);
    check("R12 no withhold", withhold, 0);
    rx_ls = L_I;
    wait_st(S_JOIN, 100, c);
    check("R10 join", state_o, S_JOIN);
    check("R2 join halt", tx_ls, T_H);
    rx_ls = L_H;
    wait_st(S_VER, 100, c);
    check("R10 verify", state_o, S_VER);
    check("R2 verify master", tx_ls, T_M);
    rx_ls = L_M;
    wait_st(S_ACT, 100, c);
    check("R10 active", link_up, 1);
    check("R10 stale master no trace", trace_prop, 0);
    check("R2 active idle", tx_ls, T_I);
    if (to_halt) begin
      rx_ls = L_H;
      wait_st(S_BRK, 10, c);
      check("R10 halt breaks active", state_o, S_BRK);
    end else begin
      rx_ls = L_I; step(IDLE_MIN + 4);
      check("R10 pass-through", tx_ls, T_P);
      rx_ls = L_M; step(3);
      check("R10 trace propagate", trace_prop, 1);
      pulse(trace_req);
      check("R13 trace entered", state_o, S_TRC);
      check("R2 trace master", tx_ls, T_M);
      rx_ls = L_Q; step(20);
      rx_ls = L_H; step(20);
      check("R13 trace holds", state_o, S_TRC);
      pulse(stop_req);
      check("R3 stop to off", state_o, S_OFF);
    end
  endtask

  task automatic t_withhold();
    int c;
    to_next();
    run_bits(10'b0000001110, 10'b0000001110, LC_SHORT);
    check("R12 withhold", withhold, 1);
    rx_ls = L_I;
    wait_st(S_BRK, 100, c);
    check("R12 withheld goes to break", state_o, S_BRK);
    check("R12 withhold held in break", withhold, 1);
  endtask

  task automatic t_quiet_signal();
    int c;
    to_next();
    rx_ls = L_I;
    wait_st(S_SIG, 100, c);
    rx_ls = L_Q;
    wait_st(S_BRK, 10, c);
    check("R8 quiet in signal", c, 2);
  endtask

  task automatic t_maint();
    to_next();
    maint_ls = T_H;
    pulse(dis_req);
    check("R13 maintenance", state_o, S_MNT);
    check("R13 forced tx", tx_ls, T_H);
    rx_ls = L_Q;
    pulse(stop_req);
    pulse(start_req);
    step(10);
    check("R13 requests ignored", state_o, S_MNT);
    maint_ls = T_M; step(1);
    check("R13 forced tx follows", tx_ls, T_M);
    pulse(en_req);
    check("R13 enable to off", state_o, S_OFF);
    check("R2 off quiet", tx_ls, T_Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    t_reset();
    t_break();
    t_connect();
    t_full(1'b0);
    to_next();
    t_full(1'b1);
    t_withhold();
    t_quiet_signal();
    t_maint();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule